// File: doc/BRIEF.md
# Frame Buffer Scan-Out Address Generator

This block turns a true-colour picture held in ordinary memory into a stream of pixels for a display. It counts through the video frame, one pixel per clock. During the visible area it issues one word read per pixel to a simple pipelined memory read port. It splits each returned 32-bit word into 8-bit red, green and blue. It drives data-enable plus active-low horizontal and vertical sync, delayed by the memory latency so that they line up with the pixels. By default the frame is 640x480 inside an 800x525 clock frame. The timing figures are parameters, so that a smaller frame can be used during verification.

Software sets two word-indexed registers through a small write/read port. Index 0 holds the picture base. Only its upper 11 bits are kept, which puts the buffer on a 2 MiB boundary. Index 1 holds the control word: bit 0 turns the display on and bit 1 turns the picture by 180 degrees. Every picture row takes 1024 words of memory. Only the leading visible columns are read, and the rest of the row is skipped. The base and rotation settings are copied into working registers only at the frame boundary. The enable bit acts at once.

The `rst_n` input is an asynchronous active-low reset. It is expected to be released in step with `clk`.

Top module: `fbscan_top`

## Requirements
- R1: A line lasts HA+HFP+HS+HB clocks and a frame lasts VA+VFP+VS+VB lines. `pix_de` is high for the first HA clocks of each of the first VA lines, delayed by RD_LAT clocks. Defaults are 640/16/96/48 and 480/10/2/33. After reset, `pix_de` is low and both syncs are high.
- R2: `hsync_n` is low for the HS clocks that follow the horizontal front porch. `vsync_n` is low for the VS lines that follow the vertical front porch. Both carry the same RD_LAT delay as `pix_de`.
- R3: In a pixel word, bits 23:16 give `pix_r`, bits 15:8 give `pix_g` and bits 7:0 give `pix_b`. Bits 31:24 have no effect.
- R4: Register index 0 keeps write-data bits 31:21 and reads back zero in bits 20:0. Register index 1 keeps bit 0 (enable) and bit 1 (rotate) and reads zero elsewhere. Both registers are zero after reset.
- R5: While the enable bit is 0, `mem_rd` stays low and the colour outputs are 0, while the sync and `pix_de` timing continues. Writing 0 to index 1 turns the display off. Writing 1 or 3 turns it on again, starting in the next clock.
- R6: Without rotation, each visible pixel at row r and column c issues one read at word address (base>>2) + r*1024 + c, in raster order. Columns HA and above are never addressed.
- R7: With rotation, the row is replaced by VA-1-r and the column by HA-1-c, so the scan runs from the last row and column back to row 0, column 0.
- R8: A write to the base or rotate field takes effect only from the first pixel of the next frame. The frame in progress keeps its old settings.
- R9: Data that arrives on `mem_rdata` RD_LAT clocks after a read is shown in the clock where the delayed `pix_de` is high. Colour outputs are 0 whenever `pix_de` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 1 | Register word index (0 base, 1 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 30 | Memory word address |
| mem_rdata | input | 32 | Memory read data, RD_LAT clocks after the request |
| pix_r | output | 8 | Red level |
| pix_g | output | 8 | Green level |
| pix_b | output | 8 | Blue level |
| pix_de | output | 1 | Data enable |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The scan is run in four cases: plain raster order, reversed order, base and rotate writes made in the middle of a frame, and the display turned off. Comparing raster with reversed order separates the row and column mirroring from the plain offset arithmetic. The mid-frame writes show whether settings leak into the frame in progress. With the display off, the memory returns random data on every unused cycle, so any leak of data that was never requested shows up as coloured pixels. A run of random register writes at random times mixes all of these, and every register readback is compared with the masked value written.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

  // One entry of the delay line that keeps video timing aligned with memory data
  typedef struct packed {
    logic de;
    logic hs_n;
    logic vs_n;
    logic rd;
  } scan_tag_t;

  localparam scan_tag_t TAG_IDLE = '{de: 1'b0, hs_n: 1'b1, vs_n: 1'b1, rd: 1'b0};

endpackage

// File: rtl/fbscan_regs.sv
module fbscan_regs #(
  parameter int DW   = 32,
  parameter int KEEP = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            frame_end,
  output logic            en_live,
  output logic            rot_sh,
  output logic [KEEP-1:0] base_sh
);

  logic [KEEP-1:0] base_q, base_d;
  logic            en_q, en_d;
  logic            rot_q, rot_d;
  logic            unused_wdata;

  assign unused_wdata = ^wdata[DW-KEEP-1:2];

  always_comb begin
    base_d = base_q;
    en_d   = en_q;
    rot_d  = rot_q;
    if (wr && !idx) base_d = wdata[DW-1 -: KEEP];
    if (wr && idx) begin
      en_d  = wdata[0];
      rot_d = wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
      rot_q  <= 1'b0;
    end else if (wr) begin
      base_q <= base_d;
      en_q   <= en_d;
      rot_q  <= rot_d;
    end
  end

  // working copies, loaded only on the last clock of a frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_sh <= '0;
      rot_sh  <= 1'b0;
    end else if (frame_end) begin
      base_sh <= base_q;
      rot_sh  <= rot_q;
    end
  end

  assign en_live = en_q;
  assign rdata   = idx ? {{(DW-2){1'b0}}, rot_q, en_q}
                       : {base_q, {(DW-KEEP){1'b0}}};

endmodule

// File: rtl/fbscan_timing.sv
module fbscan_timing #(
  parameter int HA  = 640,
  parameter int HFP = 16,
  parameter int HS  = 96,
  parameter int HB  = 48,
  parameter int VA  = 480,
  parameter int VFP = 10,
  parameter int VS  = 2,
  parameter int VB  = 33,
  localparam int HT = HA + HFP + HS + HB,
  localparam int VT = VA + VFP + VS + VB,
  localparam int HW = $clog2(HT),
  localparam int VW = $clog2(VT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hc,
  output logic [VW-1:0] vc,
  output logic          vis,
  output logic          hs_n,
  output logic          vs_n,
  output logic          frame_end
);

  localparam logic [HW-1:0] H_LAST = HW'(HT - 1);
  localparam logic [HW-1:0] H_VIS  = HW'(HA);
  localparam logic [HW-1:0] H_S0   = HW'(HA + HFP);
  localparam logic [HW-1:0] H_S1   = HW'(HA + HFP + HS);
  localparam logic [VW-1:0] V_LAST = VW'(VT - 1);
  localparam logic [VW-1:0] V_VIS  = VW'(VA);
  localparam logic [VW-1:0] V_S0   = VW'(VA + VFP);
  localparam logic [VW-1:0] V_S1   = VW'(VA + VFP + VS);

  logic [HW-1:0] hc_d;
  logic [VW-1:0] vc_d;
  logic          line_end;

  assign line_end = (hc == H_LAST);

  always_comb begin
    hc_d = line_end ? '0 : hc + 1'b1;
    vc_d = (vc == V_LAST) ? '0 : vc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc <= '0;
    else        hc <= hc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vc <= '0;
    else if (line_end) vc <= vc_d;
  end

  assign vis       = (hc < H_VIS) && (vc < V_VIS);
  assign hs_n      = !((hc >= H_S0) && (hc < H_S1));
  assign vs_n      = !((vc >= V_S0) && (vc < V_S1));
  assign frame_end = line_end && (vc == V_LAST);

endmodule

// File: rtl/fbscan_fetch.sv
module fbscan_fetch #(
  parameter int HA    = 640,
  parameter int VA    = 480,
  parameter int HW    = 10,
  parameter int VW    = 10,
  parameter int KEEP  = 11,
  parameter int PITCH = 10,
  parameter int MAW   = 30
) (
  input  logic            vis,
  input  logic            en,
  input  logic            rot,
  input  logic [KEEP-1:0] base_hi,
  input  logic [HW-1:0]   hc,
  input  logic [VW-1:0]   vc,
  output logic            mem_rd,
  output logic [MAW-1:0]  mem_addr
);

  localparam logic [MAW-1:0] ROW_TOP = MAW'(VA - 1);
  localparam logic [MAW-1:0] COL_TOP = MAW'(HA - 1);

  logic [MAW-1:0] row_w, col_w, row_e, col_e, base_w;

  always_comb begin
    row_w  = MAW'(vc);
    col_w  = MAW'(hc);
    row_e  = rot ? (ROW_TOP - row_w) : row_w;
    col_e  = rot ? (COL_TOP - col_w) : col_w;
    base_w = {base_hi, {(MAW-KEEP){1'b0}}};
  end

  assign mem_addr = base_w + (row_e << PITCH) + col_e;
  assign mem_rd   = vis && en;

endmodule

// File: rtl/fbscan_top.sv
module fbscan_top #(
  parameter int HA     = 640,
  parameter int HFP    = 16,
  parameter int HS     = 96,
  parameter int HB     = 48,
  parameter int VA     = 480,
  parameter int VFP    = 10,
  parameter int VS     = 2,
  parameter int VB     = 33,
  parameter int RD_LAT = 2,
  parameter int KEEP   = 11,
  parameter int PITCH  = 10,
  localparam int DW    = 32,
  localparam int MAW   = DW - 2,
  localparam int HW    = $clog2(HA + HFP + HS + HB),
  localparam int VW    = $clog2(VA + VFP + VS + VB)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_idx,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           mem_rd,
  output logic [MAW-1:0] mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  output logic [7:0]     pix_r,
  output logic [7:0]     pix_g,
  output logic [7:0]     pix_b,
  output logic           pix_de,
  output logic           hsync_n,
  output logic           vsync_n
);
  import fbscan_pkg::*;

  logic            en_live, rot_sh, frame_end;
  logic [KEEP-1:0] base_sh;
  logic [HW-1:0]   hc;
  logic [VW-1:0]   vc;
  logic            vis, hs_raw, vs_raw;
  scan_tag_t       head;
  scan_tag_t       stg_q [RD_LAT];
  scan_tag_t       tail;
  logic            unused_pad;

  fbscan_regs #(.DW(DW), .KEEP(KEEP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_idx),
    .wdata(reg_wdata), .rdata(reg_rdata), .frame_end(frame_end),
    .en_live(en_live), .rot_sh(rot_sh), .base_sh(base_sh)
  );

  fbscan_timing #(
    .HA(HA), .HFP(HFP), .HS(HS), .HB(HB),
    .VA(VA), .VFP(VFP), .VS(VS), .VB(VB)
  ) u_tim (
    .clk(clk), .rst_n(rst_n), .hc(hc), .vc(vc), .vis(vis),
    .hs_n(hs_raw), .vs_n(vs_raw), .frame_end(frame_end)
  );

  fbscan_fetch #(
    .HA(HA), .VA(VA), .HW(HW), .VW(VW),
    .KEEP(KEEP), .PITCH(PITCH), .MAW(MAW)
  ) u_fetch (
    .vis(vis), .en(en_live), .rot(rot_sh), .base_hi(base_sh),
    .hc(hc), .vc(vc), .mem_rd(mem_rd), .mem_addr(mem_addr)
  );

  assign head = '{de: vis, hs_n: hs_raw, vs_n: vs_raw, rd: mem_rd};

  // timing travels alongside the memory pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RD_LAT; i++) stg_q[i] <= TAG_IDLE;
    end else begin
      stg_q[0] <= head;
      for (int i = 1; i < RD_LAT; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign tail       = stg_q[RD_LAT-1];
  assign unused_pad = ^mem_rdata[DW-1:24];

  assign pix_de  = tail.de;
  assign hsync_n = tail.hs_n;
  assign vsync_n = tail.vs_n;
  assign pix_r   = tail.rd ? mem_rdata[23:16] : 8'd0;
  assign pix_g   = tail.rd ? mem_rdata[15:8]  : 8'd0;
  assign pix_b   = tail.rd ? mem_rdata[7:0]   : 8'd0;

endmodule

// File: rtl/fbscan_chk.sv
module fbscan_chk #(
  parameter int MAW  = 30,
  parameter int KEEP = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_live,
  input logic            mem_rd,
  input logic [MAW-1:0]  mem_addr,
  input logic [KEEP-1:0] base_sh,
  input logic            rot_sh,
  input logic            frame_end,
  input logic            pix_de,
  input logic [7:0]      pix_r,
  input logic [7:0]      pix_g,
  input logic [7:0]      pix_b,
  input logic            reg_idx,
  input logic [31:0]     reg_rdata
);

  a_r5_no_read_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_live |-> !mem_rd);

  a_r9_black_outside_de: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_de |-> (pix_r == 8'd0 && pix_g == 8'd0 && pix_b == 8'd0));

  a_r4_base_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_idx |-> (reg_rdata[31-KEEP:0] == '0));

  a_r8_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(base_sh) && $stable(rot_sh)));

  a_r6_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[MAW-1 -: KEEP] == base_sh));

endmodule

bind fbscan_top fbscan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_live(en_live), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .base_sh(base_sh), .rot_sh(rot_sh),
  .frame_end(frame_end), .pix_de(pix_de), .pix_r(pix_r), .pix_g(pix_g),
  .pix_b(pix_b), .reg_idx(reg_idx), .reg_rdata(reg_rdata)
);

// File: tb/sim_fbscan_top.sv
`timescale 1ns/100ps
module sim_fbscan_top;
  localparam int HA = 8, HFP = 2, HS = 3, HB = 2;
  localparam int VA = 4, VFP = 1, VS = 2, VB = 1;
  localparam int HT = HA + HFP + HS + HB;
  localparam int VT = VA + VFP + VS + VB;
  localparam int LAT = 3;

  logic        clk, rst_n;
  logic        reg_wr, reg_idx;
  logic [31:0] reg_wdata, reg_rdata, mem_rdata;
  logic        mem_rd;
  logic [29:0] mem_addr;
  logic [7:0]  pix_r, pix_g, pix_b;
  logic        pix_de, hsync_n, vsync_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  fbscan_top #(.HA(HA), .HFP(HFP), .HS(HS), .HB(HB), .VA(VA), .VFP(VFP),
               .VS(VS), .VB(VB), .RD_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pix_r(pix_r),
    .pix_g(pix_g), .pix_b(pix_b), .pix_de(pix_de), .hsync_n(hsync_n),
    .vsync_n(vsync_n));

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] mword(input logic [29:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'hA5C3_0F00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // bench reference of the requirements
  typedef struct packed { logic de; logic hs; logic vs; logic rd; logic [23:0] rgb; } ex_t;
  int rh, rv;
  logic m_en, m_rot, s_rot;
  logic [10:0] m_base, s_base;
  ex_t ex [LAT];
  logic [31:0] md [LAT];
  logic e_vis, e_hs, e_vs, e_rd;
  logic [29:0] e_addr;

  always_comb begin
    int row, col;
    e_vis = (rh < HA) && (rv < VA);
    e_hs  = !((rh >= HA + HFP) && (rh < HA + HFP + HS));
    e_vs  = !((rv >= VA + VFP) && (rv < VA + VFP + VS));
    e_rd  = e_vis && m_en;
    row   = s_rot ? (VA - 1 - rv) : rv;
    col   = s_rot ? (HA - 1 - rh) : rh;
    e_addr = {s_base, 19'd0} + 30'(row * 1024 + col);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rh <= 0; rv <= 0; m_en <= 0; m_rot <= 0; s_rot <= 0;
      m_base <= 0; s_base <= 0;
      for (int i = 0; i < LAT; i++) ex[i] <= '{de:0, hs:1, vs:1, rd:0, rgb:0};
    end else begin
      rh <= (rh == HT - 1) ? 0 : rh + 1;
      if (rh == HT - 1) rv <= (rv == VT - 1) ? 0 : rv + 1;
      if (rh == HT - 1 && rv == VT - 1) begin
        s_base <= m_base; s_rot <= m_rot;
      end
      if (reg_wr && !reg_idx) m_base <= reg_wdata[31:21];
      if (reg_wr && reg_idx) begin m_en <= reg_wdata[0]; m_rot <= reg_wdata[1]; end
      ex[0] <= '{de:e_vis, hs:e_hs, vs:e_vs, rd:e_rd, rgb:(e_rd ? mword(e_addr)[23:0] : 24'd0)};
      for (int i = 1; i < LAT; i++) ex[i] <= ex[i-1];
    end
  end

  // memory model: requested data after LAT clocks, noise otherwise
  always @(posedge clk) begin
    md[0] <= mem_rd ? mword(mem_addr) : $urandom;
    for (int i = 1; i < LAT; i++) md[i] <= md[i-1];
  end
  assign mem_rdata = md[LAT-1];

  // per-cycle comparison, away from the active edge
  bit run_chk = 0;
  always @(negedge clk) begin
    if (rst_n && run_chk && !done) begin
      ex_t t;
      t = ex[LAT-1];
      chk(mem_rd == e_rd, m_en ? "R6 read strobe" : "R5 no read while off", 32'(mem_rd), 32'(e_rd));
      if (e_rd)
        chk(mem_addr == e_addr,
            (m_base != s_base || m_rot != s_rot) ? "R8 old settings kept" : (s_rot ? "R7 reversed addr" : "R6 raster addr"),
            32'(mem_addr), 32'(e_addr));
      chk(pix_de == t.de, "R1 data enable", 32'(pix_de), 32'(t.de));
      chk(hsync_n == t.hs && vsync_n == t.vs, "R2 sync", {30'd0, hsync_n, vsync_n}, {30'd0, t.hs, t.vs});
      chk({pix_r, pix_g, pix_b} == t.rgb,
          !t.de ? "R9 black outside de" : (!t.rd ? "R5 black while off" : "R3 colour unpack"),
          {8'd0, pix_r, pix_g, pix_b}, {8'd0, t.rgb});
    end
  end

  logic [31:0] sw_base, sw_ctrl;

  task automatic wr(input logic idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_idx = idx; reg_wdata = d;
    if (!idx) sw_base = d & 32'hFFE0_0000; else sw_ctrl = d & 32'h3;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rdchk(input logic idx);
    @(negedge clk);
    reg_idx = idx;
    #1;
    chk(reg_rdata == (idx ? sw_ctrl : sw_base), idx ? "R4 control readback" : "R4 base readback",
        reg_rdata, idx ? sw_ctrl : sw_base);
  endtask

  task automatic frames(input int n);
    repeat (n * HT * VT) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; reg_wr = 0; reg_idx = 0; reg_wdata = 0;
    sw_base = 0; sw_ctrl = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pix_de == 0 && hsync_n == 1 && vsync_n == 1 && mem_rd == 0, "R1 reset state",
        {28'd0, pix_de, hsync_n, vsync_n, mem_rd}, 32'h6);
    rst_n = 1;
    run_chk = 1;
    rdchk(0); rdchk(1);
    // directed: raster scan with a base whose low bits must be dropped
    wr(0, 32'h1234_5678); rdchk(0);
    wr(1, 32'hFFFF_FFF1); rdchk(1);
    frames(2);
    // rotation switched on mid-frame
    repeat (37) @(posedge clk);
    wr(1, 32'h3); rdchk(1);
    frames(2);
    // base moved mid-frame while rotated
    repeat (51) @(posedge clk);
    wr(0, 32'hFFFF_FFFF); rdchk(0);
    frames(2);
    // display off, then back on
    wr(1, 32'h0); rdchk(1);
    frames(1);
    wr(1, 32'h1);
    frames(1);
    // random register traffic
    for (int k = 0; k < 40; k++) begin
      repeat ($urandom_range(0, 150)) @(posedge clk);
      wr(1'($urandom_range(0, 1)), $urandom);
      rdchk(0); rdchk(1);
    end
    frames(1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not finish actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule